// File: doc/BRIEF.md
# SPI Flash Page-Program Write Buffer

This block is the buffered programming path of a serial NOR flash controller. A shared 128-byte buffer serves either as a read prefetch store or as a page-program store, and a mode bit picks between the two. Software first selects program mode and reads the bit back to confirm the switch. It then writes the flash address one byte at a time and fills the buffer with 32 word writes to a single data port. A program command then sends the whole page on one serial line. A second command writes one byte without using the buffer. Write-enable sequencing and polling of the flash's busy flag remain with software.

The serial frame carries one bit per clock. Chip select stays low for the whole frame. The controller FSM has three states. `ST_IDLE` waits for a command. `ST_SHIFT` drives the frame. `ST_END` holds chip select high for one cycle before the command bit clears. There are four transitions: an accepted command moves IDLE to SHIFT; SHIFT stays in SHIFT between bits; the last bit moves SHIFT to END; END always returns to IDLE.

Top module: `spi_pp_wbuf`

## Requirements
- R1: After reset, `cs_n` is 1, `sout` is 0, `cmd_busy` is 0 and `mode_rb` is 0 (prefetch role).
- R2: When `mode_wr` is high with `cmd_busy` low, `mode_rb` takes the value of `mode_val` on the next cycle (1 = page program, 0 = read prefetch). A `mode_wr` that arrives while `cmd_busy` is high is ignored.
- R3: Command value 0x10 in program mode sends a frame of 1056 bits, most significant bit of each byte first, one bit per clock, with `cs_n` low throughout. The frame is the opcode 0x02, then address bits 23:0, then buffer bytes 0 to 127 in ascending order.
- R4: In each word written through `data_word`, bits 7:0 hold the lowest-addressed of its four buffer bytes and bits 31:24 hold the highest.
- R5: `addr_sel` values 0, 1 and 2 write address bytes 0 (bits 7:0), 1 and 2. Value 3 writes the most significant byte, bits 31:24. Only bits 23:0 appear on the line.
- R6: Command 0x10 issued in prefetch mode is rejected. `cmd_busy` stays low and `cs_n` stays high.
- R7: Command value 0x90 sends a 40-bit frame: opcode 0x02, address bits 23:0, and the `wr_byte` value captured with the command. It runs in either mode.
- R8: `cmd_busy` rises on the cycle after a command is accepted. It stays high while `cs_n` is low and for one cycle after `cs_n` rises, then falls.
- R9: Entering program mode from prefetch mode resets the word pointer to 0. After 32 words, further data writes are ignored.
- R10: Command values other than 0x10 and 0x90 are ignored. Any command issued while `cmd_busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wr | input | 1 | Strobe to write the buffer role bit |
| mode_val | input | 1 | New role: 1 page program, 0 read prefetch |
| mode_rb | output | 1 | Role bit currently in effect |
| addr_wr | input | 1 | Strobe to write one address byte |
| addr_sel | input | 2 | Address byte lane: 0..2 low bytes, 3 top byte |
| addr_byte | input | 8 | Address byte value |
| data_wr | input | 1 | Strobe to push one word into the buffer |
| data_word | input | 32 | Buffer word, little-endian byte lanes |
| wr_byte | input | 8 | Data byte for the single-byte write command |
| cmd_wr | input | 1 | Command strobe |
| cmd_val | input | 8 | Command value (0x10 page program, 0x90 single byte) |
| cmd_busy | output | 1 | Command bit, high until the transfer is done |
| cs_n | output | 1 | Flash chip select, active low |
| sout | output | 1 | Serial data to the flash, one bit per clock |

## Verification
The hardest states to reach from the ports are the word pointer held at its limit and the pointer reset on re-entry to program mode. Neither is visible directly. The bench reaches both by writing a 33rd word that must not appear on the line. It then toggles the mode off and on, loads only two new words, and expects a page whose first eight bytes are new and whose other bytes are from the earlier load. Ignored commands and mode writes are issued in the middle of a 1056-bit frame. The scoreboard then shows that the frame ran undisturbed and that no second frame followed.

// File: rtl/spi_pp_pkg.sv
package spi_pp_pkg;
    localparam logic [7:0] CMD_PAGE_PROG = 8'h10;
    localparam logic [7:0] CMD_PIO_WRITE = 8'h90;
    localparam logic [7:0] FLASH_OP_PP   = 8'h02;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_END   = 2'd2
    } pp_state_t;
endpackage

// File: rtl/pp_addr_reg.sv
module pp_addr_reg #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [1:0]    sel,
    input  logic [7:0]    byte_in,
    output logic [AW-1:0] addr
);
    localparam int NB = AW / 8;

    logic [NB-1:0][7:0] lanes;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lanes <= '0;
        end else if (wr) begin
            lanes[sel] <= byte_in;
        end
    end

    assign addr = lanes;
endmodule

// File: rtl/pp_wbuf.sv
module pp_wbuf #(
    parameter int WORDS = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         we,
    input  logic [31:0]                  wdata,
    input  logic [$clog2(WORDS*4)-1:0]   rd_idx,
    output logic [7:0]                   rd_byte
);
    localparam int PW = $clog2(WORDS + 1);
    localparam int WI = $clog2(WORDS);

    logic [31:0]   mem [WORDS];
    logic [PW-1:0] ptr;
    logic [31:0]   word_sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (clr) begin
            ptr <= '0;
        end else if (we && (ptr < PW'(WORDS))) begin
            ptr <= ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!clr && we && (ptr < PW'(WORDS))) begin
            mem[ptr[WI-1:0]] <= wdata;
        end
    end

    assign word_sel = mem[rd_idx[WI+1:2]];

    always_comb begin
        unique case (rd_idx[1:0])
            2'd0: rd_byte = word_sel[7:0];
            2'd1: rd_byte = word_sel[15:8];
            2'd2: rd_byte = word_sel[23:16];
            default: rd_byte = word_sel[31:24];
        endcase
    end

    // R9
    ptr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= PW'(WORDS));

    // R9
    ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> ptr == '0);
endmodule

// File: rtl/spi_pp_wbuf.sv
module spi_pp_wbuf
    import spi_pp_pkg::*;
#(
    parameter int WORDS = 32,
    parameter int AW    = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mode_wr,
    input  logic        mode_val,
    output logic        mode_rb,
    input  logic        addr_wr,
    input  logic [1:0]  addr_sel,
    input  logic [7:0]  addr_byte,
    input  logic        data_wr,
    input  logic [31:0] data_word,
    input  logic [7:0]  wr_byte,
    input  logic        cmd_wr,
    input  logic [7:0]  cmd_val,
    output logic        cmd_busy,
    output logic        cs_n,
    output logic        sout
);
    localparam int NBYTES = WORDS * 4;
    localparam int BI_W   = $clog2(NBYTES);
    localparam int IDX_W  = $clog2(NBYTES + 4);

    pp_state_t        state, state_nx;
    logic             mode_q;
    logic             is_pp;
    logic [7:0]       wd_q;
    logic [IDX_W-1:0] byte_idx;
    logic [2:0]       bit_idx;
    logic [IDX_W-1:0] last_idx;
    logic [IDX_W-1:0] buf_off;
    logic [AW-1:0]    addr;
    logic [7:0]       buf_byte;
    logic [7:0]       cur_byte;
    logic             accept;
    logic             busy;
    logic             frame_end;

    assign busy     = (state != ST_IDLE);
    assign accept   = !busy && cmd_wr &&
                      (((cmd_val == CMD_PAGE_PROG) && mode_q) || (cmd_val == CMD_PIO_WRITE));
    assign last_idx = is_pp ? IDX_W'(NBYTES + 3) : IDX_W'(4);
    assign frame_end = (bit_idx == 3'd7) && (byte_idx == last_idx);
    assign buf_off  = byte_idx - IDX_W'(4);

    pp_addr_reg #(.AW(AW)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (addr_wr),
        .sel     (addr_sel),
        .byte_in (addr_byte),
        .addr    (addr)
    );

    pp_wbuf #(.WORDS(WORDS)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (mode_wr && !busy && mode_val && !mode_q),
        .we      (data_wr && mode_q),
        .wdata   (data_word),
        .rd_idx  (buf_off[BI_W-1:0]),
        .rd_byte (buf_byte)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (accept) state_nx = ST_SHIFT;
            ST_SHIFT: if (frame_end) state_nx = ST_END;
            ST_END:   state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            mode_q   <= 1'b0;
            is_pp    <= 1'b0;
            wd_q     <= '0;
            byte_idx <= '0;
            bit_idx  <= '0;
        end else begin
            state <= state_nx;
            if (mode_wr && !busy) mode_q <= mode_val;
            if (accept) begin
                is_pp    <= (cmd_val == CMD_PAGE_PROG);
                wd_q     <= wr_byte;
                byte_idx <= '0;
                bit_idx  <= '0;
            end else if (state == ST_SHIFT) begin
                bit_idx <= bit_idx + 3'd1;
                if (bit_idx == 3'd7) byte_idx <= byte_idx + 1'b1;
            end
        end
    end

    always_comb begin
        unique case (byte_idx)
            IDX_W'(0): cur_byte = FLASH_OP_PP;
            IDX_W'(1): cur_byte = addr[23:16];
            IDX_W'(2): cur_byte = addr[15:8];
            IDX_W'(3): cur_byte = addr[7:0];
            default:   cur_byte = is_pp ? buf_byte : wd_q;
        endcase
    end

    always_comb begin
        cs_n     = (state != ST_SHIFT);
        sout     = (state == ST_SHIFT) ? cur_byte[3'd7 - bit_idx] : 1'b0;
        cmd_busy = busy;
        mode_rb  = mode_q;
    end

    // R8
    cs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> cmd_busy);

    // R8
    busy_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> cmd_busy ##1 !cmd_busy);

    // R6
    pp_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !cmd_busy && !mode_rb && cmd_val == CMD_PAGE_PROG) |=> !cmd_busy);

    // R2
    mode_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && !cmd_busy) |=> mode_rb == $past(mode_val));

    // R3
    opcode_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> !sout);
endmodule

// File: tb/spi_pp_wbuf_bench.sv
module spi_pp_wbuf_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_wr = 0, mode_val = 0, addr_wr = 0, data_wr = 0, cmd_wr = 0;
    logic [1:0]  addr_sel = 0;
    logic [7:0]  addr_byte = 0, wr_byte = 0, cmd_val = 0;
    logic [31:0] data_word = 0;
    logic        mode_rb, cmd_busy, cs_n, sout;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    bit exp_q[$];
    logic [7:0] page [128];

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_pp_wbuf u_spi_pp_wbuf (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_val(mode_val),
        .mode_rb(mode_rb), .addr_wr(addr_wr), .addr_sel(addr_sel),
        .addr_byte(addr_byte), .data_wr(data_wr), .data_word(data_word),
        .wr_byte(wr_byte), .cmd_wr(cmd_wr), .cmd_val(cmd_val),
        .cmd_busy(cmd_busy), .cs_n(cs_n), .sout(sout)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: one expected bit per cycle with cs_n low (R3, R4, R5, R7)
    always @(negedge clk) begin
        if (rst_n && !cs_n) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10 unexpected frame bit", sout, 0);
            end else begin
                bit e;
                e = exp_q.pop_front();
                check(sout == e, "R3 serial bit", sout, e);
            end
        end
    end

    task automatic push_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) exp_q.push_back(b[i]);
    endtask

    task automatic push_head(input logic [31:0] a);
        push_byte(8'h02); push_byte(a[23:16]); push_byte(a[15:8]); push_byte(a[7:0]);
    endtask

    task automatic pulse_mode(input logic v);
        @(negedge clk); mode_wr = 1; mode_val = v;
        @(negedge clk); mode_wr = 0;
    endtask

    task automatic set_addr(input logic [31:0] a);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); addr_wr = 1; addr_sel = 2'(i); addr_byte = a[8*i +: 8];
        end
        @(negedge clk); addr_wr = 0;
    endtask

    task automatic push_word(input logic [31:0] w);
        @(negedge clk); data_wr = 1; data_word = w;
        @(negedge clk); data_wr = 0;
    endtask

    task automatic issue(input logic [7:0] c, input logic [7:0] b);
        @(negedge clk); cmd_wr = 1; cmd_val = c; wr_byte = b;
        @(negedge clk); cmd_wr = 0;
    endtask

    task automatic wait_idle();
        while (cmd_busy) @(negedge clk);
        check(exp_q.size() == 0, "R3 frame length", exp_q.size(), 0);
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] a;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(cs_n == 1 && sout == 0 && cmd_busy == 0 && mode_rb == 0, "R1 reset", {cs_n, sout, cmd_busy, mode_rb}, 4'b1000);
        rst_n = 1;
        a = 32'h44332211;
        set_addr(a);

        // R6 page program in prefetch mode rejected
        issue(8'h10, 8'h00);
        check(cmd_busy == 0, "R6 busy", cmd_busy, 0);
        repeat (3) @(negedge clk);
        check(cs_n == 1, "R6 cs_n", cs_n, 1);

        // R2 mode switch
        pulse_mode(1);
        check(mode_rb == 1, "R2 mode readback", mode_rb, 1);

        // R4 R9 load 32 words + one extra ignored
        for (int w = 0; w < 32; w++) begin
            logic [31:0] d;
            d = {8'(4*w+3) ^ 8'hA0, 8'(4*w+2) ^ 8'h5C, 8'(4*w+1), 8'(4*w) ^ 8'h33};
            for (int k = 0; k < 4; k++) page[4*w+k] = d[8*k +: 8];
            push_word(d);
        end
        push_word(32'hDEADBEEF);

        // R3 R5 full page frame; R10 and R2 stimulus during the frame
        push_head(a);
        for (int i = 0; i < 128; i++) push_byte(page[i]);
        issue(8'h10, 8'h00);
        check(cmd_busy == 1, "R8 busy after accept", cmd_busy, 1);
        repeat (50) @(negedge clk);
        issue(8'h90, 8'h77);
        pulse_mode(0);
        wait_idle();
        check(mode_rb == 1, "R2 mode write while busy ignored", mode_rb, 1);
        repeat (5) @(negedge clk);
        check(cs_n == 1 && cmd_busy == 0, "R10 no frame after ignored cmd", cs_n, 1);

        // R10 unknown command
        issue(8'h55, 8'h00);
        check(cmd_busy == 0, "R10 unknown command", cmd_busy, 0);

        // R9 pointer reset on re-entry
        pulse_mode(0);
        check(mode_rb == 0, "R2 back to prefetch", mode_rb, 0);
        pulse_mode(1);
        push_word(32'h03020100);
        push_word(32'h07060504);
        for (int i = 0; i < 8; i++) page[i] = 8'(i);
        a = 32'hFF00C0DE;
        set_addr(a);
        push_head(a);
        for (int i = 0; i < 128; i++) push_byte(page[i]);
        issue(8'h10, 8'h00);
        wait_idle();

        // R7 single byte write in prefetch mode
        pulse_mode(0);
        a = 32'h12ABCDEF;
        set_addr(a);
        push_head(a);
        push_byte(8'hA5);
        issue(8'h90, 8'hA5);
        check(cmd_busy == 1, "R7 busy", cmd_busy, 1);
        wait_idle();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule